// File: doc/BRIEF.md
# Mixed-Width Register Transfer and Flag Unit

This unit carries out the register-to-register transfer instructions of a CPU whose four primary registers (A, X, Y, Z) are 16 bits wide. Each register is either wide or narrow, chosen by a width flag. When a register is narrow, its upper byte is always zero. The CPU also has two 24-bit pointers: a stack pointer and a base-page pointer. Each pointer is split into a low, a middle and a high byte lane. The unit reads the current register and pointer values and a transfer opcode. One cycle later it presents the data to write back, byte-level write enables for the destination, and the updated sign (N) and zero (Z) flags.

A transfer between two primary registers moves the whole 16-bit word. The flags follow the width of the destination, not the width of the source. A transfer into or out of a pointer uses a pair of adjacent byte lanes. The lane pair shifts with the width mode and with the register involved. Bytes outside the chosen lanes keep their values. Writing a pointer leaves the flags unchanged. The surrounding core owns the register file: it applies the write enables and feeds the stored values back.

Top module: `xfer_unit`

## Requirements
- R1: `op` is sampled on a rising edge where `opValid` is high. The results appear on the outputs after that same edge. After an edge with `opValid` low, `gprByteWe`, `spByteWe` and `bpByteWe` are all zero and `flagN`/`flagZ` keep their values.
- R2: Opcodes 0 to 5 copy one primary register into another: 0 A→X, 1 A→Y, 2 A→Z, 3 X→A, 4 Y→A, 5 Z→A. If the destination is wide, `gprData` is the full 16-bit source word. Both byte enables of the destination are raised. `gprByteWe` bit 2r+b is byte b of register r, with A=0, X=1, Y=2, Z=3. At most one destination is written per transfer.
- R3: If the destination is narrow, the upper byte of `gprData` is written as zero.
- R4: For a narrow destination, `flagZ` is set exactly when bits 7:0 of the result are zero, and `flagN` is bit 7.
- R5: For a wide destination, `flagZ` is set exactly when all 16 bits are zero, and `flagN` is bit 15.
- R6: Opcode 6 (X→stack) and opcode 8 (Y→stack) with `idxWide` low write one lane. Opcode 6 writes X[7:0] into the low lane (`spByteWe`=001). Opcode 8 writes Y[7:0] into the middle lane (`spByteWe`=010).
- R7: With `idxWide` high, opcode 6 writes X into the middle and low lanes (011). Opcode 8 writes Y into the high and middle lanes (110).
- R8: Opcode 10 (A→base) uses the width of A. Opcode 12 (X→base) uses the index width. A→base writes lane 1 when narrow, or lanes 2:1 when wide. X→base writes lane 0 when narrow, or lanes 1:0 when wide. Lane writes go through `bpByteWe`.
- R9: Opcodes 7 (stack→X), 9 (stack→Y), 11 (base→A) and 13 (base→X) read the same lanes as their inverse transfers into the destination register. The destination's width flag selects the lanes. A narrow destination gets a zero upper byte.
- R10: A pointer write leaves the flags unchanged. On `ptrData`, every lane whose enable is low carries the previous value of that pointer.
- R11: Opcodes 14 and 15 raise no write enable and leave the flags unchanged.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Transfer request this cycle |
| op | input | 4 | Transfer opcode |
| accWide | input | 1 | A is 16-bit when high |
| idxWide | input | 1 | X, Y, Z are 16-bit when high |
| aIn | input | 16 | Current A |
| xIn | input | 16 | Current X |
| yIn | input | 16 | Current Y |
| zIn | input | 16 | Current Z |
| spIn | input | 24 | Current stack pointer |
| bpIn | input | 24 | Current base-page pointer |
| gprData | output | 16 | Write data for the primary-register destination |
| gprByteWe | output | 8 | Byte enables, bit 2r+b |
| ptrData | output | 24 | Merged new pointer value |
| spByteWe | output | 3 | Stack pointer lane enables |
| bpByteWe | output | 3 | Base pointer lane enables |
| flagN | output | 1 | Sign flag |
| flagZ | output | 1 | Zero flag |

## Verification
The assertions assume that the core keeps the upper byte of every narrow register at zero. They also assume that the core holds the width flags steady for the cycle of a request. The zero-flag check compares the flag against the full 16-bit result, which is only valid when the upper byte of a narrow result is zero. To stay within these assumptions, the bench clears the upper byte of each narrow register before it drives a pattern. The bench sweeps every opcode, all four width combinations and a set of edge-case patterns: zero, high byte only, bit 7 only, bit 15 only, and mixed values.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DATA_W    = 16;
  localparam int LANE_W    = 8;
  localparam int PTR_W     = 24;
  localparam int PTR_LANES = PTR_W / LANE_W;
  localparam int GPR_COUNT = 4;
  localparam int GPR_BYTES = DATA_W / LANE_W;
  localparam int OP_W      = 4;

  typedef enum logic [OP_W-1:0] {
    OP_A2X = 4'd0,  OP_A2Y = 4'd1,  OP_A2Z = 4'd2,
    OP_X2A = 4'd3,  OP_Y2A = 4'd4,  OP_Z2A = 4'd5,
    OP_X2S = 4'd6,  OP_S2X = 4'd7,  OP_Y2S = 4'd8,  OP_S2Y = 4'd9,
    OP_A2B = 4'd10, OP_B2A = 4'd11, OP_X2B = 4'd12, OP_B2X = 4'd13,
    OP_RS14 = 4'd14, OP_RS15 = 4'd15
  } xferOp_e;

  typedef enum logic [2:0] {
    SRC_A, SRC_X, SRC_Y, SRC_Z, SRC_SP, SRC_BP
  } srcSel_e;

  typedef struct packed {
    srcSel_e                src;
    logic [GPR_COUNT-1:0]   gprDst;
    logic                   upperLane;
    logic                   wide;
    logic [PTR_LANES-1:0]   spWe;
    logic [PTR_LANES-1:0]   bpWe;
    logic                   flagWe;
  } xferStrobe_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] op,
  input  logic            accWide,
  input  logic            idxWide,
  output xferStrobe_t     strobe
);
  function automatic logic [PTR_LANES-1:0] laneSel(input logic up, input logic wide);
    logic [PTR_LANES-1:0] m;
    int base;
    m = '0;
    base = up ? 1 : 0;
    m[base] = 1'b1;
    if (wide) m[base+1] = 1'b1;
    return m;
  endfunction

  always_comb begin
    strobe = '0;
    strobe.src = SRC_A;
    if (opValid) begin
      unique case (xferOp_e'(op))
        OP_A2X: begin strobe.src = SRC_A; strobe.gprDst = 4'b0010; strobe.wide = idxWide; strobe.flagWe = 1'b1; end
        OP_A2Y: begin strobe.src = SRC_A; strobe.gprDst = 4'b0100; strobe.wide = idxWide; strobe.flagWe = 1'b1; end
        OP_A2Z: begin strobe.src = SRC_A; strobe.gprDst = 4'b1000; strobe.wide = idxWide; strobe.flagWe = 1'b1; end
        OP_X2A: begin strobe.src = SRC_X; strobe.gprDst = 4'b0001; strobe.wide = accWide; strobe.flagWe = 1'b1; end
        OP_Y2A: begin strobe.src = SRC_Y; strobe.gprDst = 4'b0001; strobe.wide = accWide; strobe.flagWe = 1'b1; end
        OP_Z2A: begin strobe.src = SRC_Z; strobe.gprDst = 4'b0001; strobe.wide = accWide; strobe.flagWe = 1'b1; end
        OP_X2S: begin
          strobe.src = SRC_X; strobe.upperLane = 1'b0; strobe.wide = idxWide;
          strobe.spWe = laneSel(1'b0, idxWide);
        end
        OP_S2X: begin
          strobe.src = SRC_SP; strobe.upperLane = 1'b0; strobe.wide = idxWide;
          strobe.gprDst = 4'b0010; strobe.flagWe = 1'b1;
        end
        OP_Y2S: begin
          strobe.src = SRC_Y; strobe.upperLane = 1'b1; strobe.wide = idxWide;
          strobe.spWe = laneSel(1'b1, idxWide);
        end
        OP_S2Y: begin
          strobe.src = SRC_SP; strobe.upperLane = 1'b1; strobe.wide = idxWide;
          strobe.gprDst = 4'b0100; strobe.flagWe = 1'b1;
        end
        OP_A2B: begin
          strobe.src = SRC_A; strobe.upperLane = 1'b1; strobe.wide = accWide;
          strobe.bpWe = laneSel(1'b1, accWide);
        end
        OP_B2A: begin
          strobe.src = SRC_BP; strobe.upperLane = 1'b1; strobe.wide = accWide;
          strobe.gprDst = 4'b0001; strobe.flagWe = 1'b1;
        end
        OP_X2B: begin
          strobe.src = SRC_X; strobe.upperLane = 1'b0; strobe.wide = idxWide;
          strobe.bpWe = laneSel(1'b0, idxWide);
        end
        OP_B2X: begin
          strobe.src = SRC_BP; strobe.upperLane = 1'b0; strobe.wide = idxWide;
          strobe.gprDst = 4'b0010; strobe.flagWe = 1'b1;
        end
        default: strobe.src = SRC_A;
      endcase
    end
  end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  xferStrobe_t                     strobe,
  input  logic [DATA_W-1:0]               aIn,
  input  logic [DATA_W-1:0]               xIn,
  input  logic [DATA_W-1:0]               yIn,
  input  logic [DATA_W-1:0]               zIn,
  input  logic [PTR_W-1:0]                spIn,
  input  logic [PTR_W-1:0]                bpIn,
  output logic [DATA_W-1:0]               gprData,
  output logic [GPR_COUNT*GPR_BYTES-1:0]  gprByteWe,
  output logic [PTR_W-1:0]                ptrData,
  output logic [PTR_LANES-1:0]            spByteWe,
  output logic [PTR_LANES-1:0]            bpByteWe,
  output logic                            flagN,
  output logic                            flagZ
);
  logic [PTR_W-1:0]                ptrSrc, ptrShifted, ptrTarget, placed, laneBits, ptrNext;
  logic [DATA_W-1:0]               srcWord, gprNext;
  logic [PTR_LANES-1:0]            laneEn;
  logic [GPR_COUNT*GPR_BYTES-1:0]  gprWeNext;
  logic                            nNext, zNext;
  int                              shamt;

  assign laneEn = strobe.spWe | strobe.bpWe;

  for (genvar l = 0; l < PTR_LANES; l++) begin : g_lane
    assign laneBits[l*LANE_W +: LANE_W] = {LANE_W{laneEn[l]}};
  end

  for (genvar r = 0; r < GPR_COUNT; r++) begin : g_gprWe
    assign gprWeNext[r*GPR_BYTES +: GPR_BYTES] = {GPR_BYTES{strobe.gprDst[r]}};
  end

  always_comb begin
    shamt      = strobe.upperLane ? LANE_W : 0;
    ptrSrc     = (strobe.src == SRC_SP) ? spIn : bpIn;
    ptrShifted = ptrSrc >> shamt;
    unique case (strobe.src)
      SRC_A:   srcWord = aIn;
      SRC_X:   srcWord = xIn;
      SRC_Y:   srcWord = yIn;
      SRC_Z:   srcWord = zIn;
      default: srcWord = ptrShifted[DATA_W-1:0];
    endcase
    gprNext = strobe.wide ? srcWord
                          : {{(DATA_W-LANE_W){1'b0}}, srcWord[LANE_W-1:0]};
    zNext = strobe.wide ? (gprNext == '0) : (gprNext[LANE_W-1:0] == '0);
    nNext = strobe.wide ? gprNext[DATA_W-1] : gprNext[LANE_W-1];
    ptrTarget = (|strobe.spWe) ? spIn : bpIn;
    placed    = PTR_W'(srcWord) << shamt;
    ptrNext   = (ptrTarget & ~laneBits) | (placed & laneBits);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gprData   <= '0;
      gprByteWe <= '0;
      ptrData   <= '0;
      spByteWe  <= '0;
      bpByteWe  <= '0;
      flagN     <= 1'b0;
      flagZ     <= 1'b0;
    end else begin
      gprData   <= gprNext;
      gprByteWe <= gprWeNext;
      ptrData   <= ptrNext;
      spByteWe  <= strobe.spWe;
      bpByteWe  <= strobe.bpWe;
      if (strobe.flagWe) begin
        flagN <= nNext;
        flagZ <= zNext;
      end
    end
  end
endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
  import xfer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            opValid,
  input  logic [OP_W-1:0]                 op,
  input  logic                            accWide,
  input  logic                            idxWide,
  input  logic [DATA_W-1:0]               aIn,
  input  logic [DATA_W-1:0]               xIn,
  input  logic [DATA_W-1:0]               yIn,
  input  logic [DATA_W-1:0]               zIn,
  input  logic [PTR_W-1:0]                spIn,
  input  logic [PTR_W-1:0]                bpIn,
  output logic [DATA_W-1:0]               gprData,
  output logic [GPR_COUNT*GPR_BYTES-1:0]  gprByteWe,
  output logic [PTR_W-1:0]                ptrData,
  output logic [PTR_LANES-1:0]            spByteWe,
  output logic [PTR_LANES-1:0]            bpByteWe,
  output logic                            flagN,
  output logic                            flagZ
);
  xferStrobe_t strobe;

  xfer_ctrl u_ctrl (
    .opValid(opValid), .op(op), .accWide(accWide), .idxWide(idxWide), .strobe(strobe)
  );

  xfer_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aIn(aIn), .xIn(xIn), .yIn(yIn), .zIn(zIn), .spIn(spIn), .bpIn(bpIn),
    .gprData(gprData), .gprByteWe(gprByteWe), .ptrData(ptrData),
    .spByteWe(spByteWe), .bpByteWe(bpByteWe), .flagN(flagN), .flagZ(flagZ)
  );
endmodule

// File: rtl/xfer_unit_chk.sv
module xfer_unit_chk
  import xfer_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            opValid,
  input logic [OP_W-1:0]                 op,
  input logic                            idxWide,
  input logic [DATA_W-1:0]               gprData,
  input logic [GPR_COUNT*GPR_BYTES-1:0]  gprByteWe,
  input logic [PTR_LANES-1:0]            spByteWe,
  input logic [PTR_LANES-1:0]            bpByteWe,
  input logic                            flagN,
  input logic                            flagZ
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (gprByteWe == '0 && spByteWe == '0 && bpByteWe == '0));

  // R11
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op >= 4'd14) |=> (gprByteWe == '0 && spByteWe == '0 && bpByteWe == '0
                                   && $stable(flagN) && $stable(flagZ)));

  // R10
  ptr_write_flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (op == 4'd6 || op == 4'd8 || op == 4'd10 || op == 4'd12))
      |=> ($stable(flagN) && $stable(flagZ)));

  // R3
  narrow_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op <= 4'd2 && !idxWide) |=> (gprData[DATA_W-1:LANE_W] == '0));

  // R4
  zero_flag_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|gprByteWe) |-> (flagZ == (gprData == '0)));

  // R2
  single_dst_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({|gprByteWe, |spByteWe, |bpByteWe}));

  // R6
  narrow_x_stack_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op == 4'd6 && !idxWide) |=> (spByteWe == 3'b001));
endmodule

bind xfer_unit xfer_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .op(op), .idxWide(idxWide),
  .gprData(gprData), .gprByteWe(gprByteWe), .spByteWe(spByteWe), .bpByteWe(bpByteWe),
  .flagN(flagN), .flagZ(flagZ)
);

// File: tb/xfer_unit_tb.sv
module xfer_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  op = '0;
  logic        accWide = 1'b0, idxWide = 1'b0;
  logic [15:0] aIn = '0, xIn = '0, yIn = '0, zIn = '0;
  logic [23:0] spIn = '0, bpIn = '0;
  logic [15:0] gprData;
  logic [7:0]  gprByteWe;
  logic [23:0] ptrData;
  logic [2:0]  spByteWe, bpByteWe;
  logic        flagN, flagZ;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;
  logic expN = 1'b0, expZ = 1'b0;

  always #2.5 clk = ~clk;

  xfer_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .op(op), .accWide(accWide), .idxWide(idxWide),
    .aIn(aIn), .xIn(xIn), .yIn(yIn), .zIn(zIn), .spIn(spIn), .bpIn(bpIn),
    .gprData(gprData), .gprByteWe(gprByteWe), .ptrData(ptrData),
    .spByteWe(spByteWe), .bpByteWe(bpByteWe), .flagN(flagN), .flagZ(flagZ)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat16(input int p, input int k);
    case (p)
      0: return 16'h0000;
      1: return 16'hFF00;
      2: return 16'h0080;
      3: return 16'h8000;
      default: return 16'((p * 40503 + k * 9973) ^ (k << 5));
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 gprData", 24'(gprData), 24'h0);
    chk("R12 enables", {13'h0, gprByteWe, spByteWe, bpByteWe}, 24'h0);
    chk("R12 flags", {22'h0, flagN, flagZ}, 24'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 7; p++) begin
        for (int o = 0; o < 16; o++) begin
          logic wAcc, wIdx, wd, up;
          logic [15:0] src, word, expG;
          logic [23:0] ptr, expP;
          logic [2:0]  lanes;
          int dst, tgt;
          string tag;
          wAcc = w[0]; wIdx = w[1];
          // narrow registers hold a zero upper byte
          aIn = pat16(p, 1)  & (wAcc ? 16'hFFFF : 16'h00FF);
          xIn = pat16(p, 2)  & (wIdx ? 16'hFFFF : 16'h00FF);
          yIn = pat16(p, 3)  & (wIdx ? 16'hFFFF : 16'h00FF);
          zIn = pat16(p, 4)  & (wIdx ? 16'hFFFF : 16'h00FF);
          spIn = {pat16(p, 5)[7:0], pat16(p, 6)};
          bpIn = {pat16(p, 7)[15:8], pat16(p, 8)};
          dst = -1; tgt = 0; up = 0; wd = wIdx; src = '0; ptr = '0;
          case (o)
            0: begin src = aIn; dst = 1; end
            1: begin src = aIn; dst = 2; end
            2: begin src = aIn; dst = 3; end
            3: begin src = xIn; dst = 0; wd = wAcc; end
            4: begin src = yIn; dst = 0; wd = wAcc; end
            5: begin src = zIn; dst = 0; wd = wAcc; end
            6: begin src = xIn; tgt = 1; end
            7: begin ptr = spIn; dst = 1; end
            8: begin src = yIn; tgt = 1; up = 1; end
            9: begin ptr = spIn; dst = 2; up = 1; end
            10: begin src = aIn; tgt = 2; up = 1; wd = wAcc; end
            11: begin ptr = bpIn; dst = 0; up = 1; wd = wAcc; end
            12: begin src = xIn; tgt = 2; end
            13: begin ptr = bpIn; dst = 1; end
            default: ;
          endcase
          if (o == 7 || o == 9 || o == 11 || o == 13) src = 16'(ptr >> (up ? 8 : 0));
          word = src;
          expG = wd ? word : {8'h00, word[7:0]};
          lanes = '0;
          if (tgt != 0) lanes = wd ? (3'b011 << up) : (3'b001 << up);
          expP = (tgt == 1) ? spIn : bpIn;
          for (int l = 0; l < 3; l++)
            if (lanes[l]) expP[l*8 +: 8] = (l - int'(up) == 0) ? word[7:0] : word[15:8];
          if (dst >= 0) begin
            expZ = wd ? (expG == 0) : (expG[7:0] == 0);
            expN = wd ? expG[15] : expG[7];
          end
          if (o <= 5)       tag = wd ? "R2" : "R3";
          else if (o >= 14) tag = "R11";
          else if (tgt == 1) tag = wd ? "R7" : "R6";
          else if (tgt == 2) tag = "R8";
          else tag = "R9";

          op = 4'(o); accWide = wAcc; idxWide = wIdx; opValid = 1'b1;
          @(negedge clk);
          opValid = 1'b0;
          chk({tag, " gprByteWe"}, 24'(gprByteWe),
              (dst >= 0) ? 24'(8'b11 << (2 * dst)) : 24'h0);
          chk({tag, " spByteWe"}, 24'(spByteWe), (tgt == 1) ? 24'(lanes) : 24'h0);
          chk({tag, " bpByteWe"}, 24'(bpByteWe), (tgt == 2) ? 24'(lanes) : 24'h0);
          if (dst >= 0) chk({tag, " gprData"}, 24'(gprData), 24'(expG));
          if (tgt != 0) chk("R10 ptrData merge", ptrData, expP);
          // R4 R5 flags by destination width; R10 R11 hold when no register written
          chk(wd ? "R5 flags" : "R4 flags", {22'h0, flagN, flagZ}, {22'h0, expN, expZ});
          @(negedge clk);
          // R1: idle cycle raises no enable and keeps flags
          chk("R1 idle enables", {13'h0, gprByteWe, spByteWe, bpByteWe}, 24'h0);
          chk("R1 idle flags", {22'h0, flagN, flagZ}, {22'h0, expN, expZ});
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule